// File: doc/BRIEF.md
# Edge-Selectable Event Counter Timer

This block is an 8-bit event counter. It is controlled and read through a small byte-wide register port. Once enabled, it counts one of two things:

- pulses of an instruction-cycle strobe supplied by the surrounding core, or
- transitions of an external event pin, of a polarity chosen in software.

The external pin is brought into the clock domain through a synchronizer chain before edges are detected. The block also reports whether a shared pin should give up its ordinary bidirectional role. It does so only while the external source is selected.

Software writes a control byte to pick the enable, the source and the edge. It can preload the count at any time. It watches a sticky overflow flag, which is set whenever the count wraps past its top value. The flag stays set until software clears it by writing a one to it. The control byte is sparse:

- some bits always read as zero;
- one bit reports the synchronized pin level and cannot be written.

Top module: `edge_event_timer`

## Requirements
- R1: After reset, the control register, the count and the overflow flag read 0, and `pinRelease` and `ovfFlag` are low.
- R2: While control bit 2 (enable) is 0, the count holds its value whatever the strobe and the pin do.
- R3: With enable set and control bit 1 (source) at 0, the count rises by exactly one on each clock with `cycleStrobe` high, and the event pin has no effect.
- R4: With enable set and source at 1, the count rises by one for each pin transition of the polarity chosen by control bit 0 (0 = low-to-high, 1 = high-to-low), and `cycleStrobe` has no effect. The count shows the change after the third rising clock edge following the pin change.
- R5: Rewriting the edge-select bit while the pin holds a steady level never changes the count.
- R6: Control byte at address 0: bits 2..0 are read/write; bits 7, 6, 4 and 3 always read 0; bit 5 reads the synchronized pin level, and writes to bit 5 are ignored.
- R7: A write to address 1 loads the count with the written byte on the next clock, and it takes priority over a count event in the same cycle.
- R8: When the count steps from 0xFF to 0x00, the overflow flag is set. It stays set until a write to address 2 with data bit 0 at 1 clears it. The flag reads as bit 0 at address 2. A wrap in the same cycle as a clear leaves it set.
- R9: `pinRelease` is high exactly when control bit 1 (source) is 1.
- R10: Address 3 reads as 0. Reads at every address have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address: 0 control, 1 count, 2 status |
| busWrite | input | 1 | Write strobe for the addressed register |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data of the addressed register (combinational) |
| eventPin | input | 1 | External event pin, asynchronous |
| cycleStrobe | input | 1 | One-clock pulse per instruction cycle |
| ovfFlag | output | 1 | Sticky overflow flag |
| pinRelease | output | 1 | High while the external source is selected |

## Verification
Directed sequences run the counter from each source in turn while the other source is kept busy. This separates correct source selection from counting everything. Steady-level pin sequences with the edge bit rewritten mid-stream separate real edge detection from level-triggered counting. Same-cycle collisions are tried on purpose: a load against an event, and a clear against a wrap. These expose a wrong priority order. Long random mixes of writes, strobes and pin toggles are then compared against a cycle model, so that latency or wrap slips show up as mismatches.

// File: rtl/edge_timer_pkg.sv
package edge_timer_pkg;
  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_COUNT  = 1;
  localparam int ADDR_STATUS = 2;

  localparam int CTRL_EDGE = 0;
  localparam int CTRL_SRC  = 1;
  localparam int CTRL_EN   = 2;
  localparam int CTRL_PIN  = 5;
  localparam int CTRL_W    = 3;

  localparam int STATUS_OVF = 0;

  typedef struct packed {
    logic loadCount;
    logic incCount;
    logic clearOvf;
  } ctrlStrobes_t;
endpackage

// File: rtl/et_counter.sv
module et_counter
  import edge_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] countVal,
  output logic             ovfFlag
);
  logic atTop;
  logic wrapNow;

  assign atTop   = &countVal;
  assign wrapNow = strobes.incCount && !strobes.loadCount && atTop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (strobes.loadCount) begin
      countVal <= loadValue;
    end else if (strobes.incCount) begin
      countVal <= countVal + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
    end else begin
      ovfFlag <= wrapNow | (ovfFlag & ~strobes.clearOvf);
    end
  end
endmodule

// File: rtl/et_control.sv
module et_control
  import edge_timer_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [CTRL_W-1:0] ctrlWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              eventPin,
  input  logic              cycleStrobe,
  input  logic [DATA_W-1:0] countVal,
  input  logic              ovfState,
  output ctrlStrobes_t      strobes,
  output logic              pinRelease
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic syncLevel;
  logic prevSample;
  logic enBit, srcBit, edgeBit;
  logic wrCtrl, wrCount, wrStatus;
  logic riseSeen, fallSeen, pinEvent, clkEvent;

  // synchronizer chain, one flop per stage
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
    if (s == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (!rstN) syncChain[s] <= 1'b0;
        else       syncChain[s] <= eventPin;
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (!rstN) syncChain[s] <= 1'b0;
        else       syncChain[s] <= syncChain[s-1];
      end
    end
  end

  assign syncLevel = syncChain[LAST_STAGE];

  always_ff @(posedge clk) begin
    if (!rstN) prevSample <= 1'b0;
    else       prevSample <= syncLevel;
  end

  assign wrCtrl   = busWrite && (busAddr == ADDR_W'(ADDR_CTRL));
  assign wrCount  = busWrite && (busAddr == ADDR_W'(ADDR_COUNT));
  assign wrStatus = busWrite && (busAddr == ADDR_W'(ADDR_STATUS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBit   <= 1'b0;
      srcBit  <= 1'b0;
      edgeBit <= 1'b0;
    end else if (wrCtrl) begin
      enBit   <= ctrlWdata[CTRL_EN];
      srcBit  <= ctrlWdata[CTRL_SRC];
      edgeBit <= ctrlWdata[CTRL_EDGE];
    end
  end

  assign riseSeen = syncLevel & ~prevSample;
  assign fallSeen = ~syncLevel & prevSample;
  assign pinEvent = srcBit & (edgeBit ? fallSeen : riseSeen);
  assign clkEvent = ~srcBit & cycleStrobe;

  always_comb begin
    strobes.loadCount = wrCount;
    strobes.incCount  = enBit & (pinEvent | clkEvent);
    strobes.clearOvf  = wrStatus & ctrlWdata[STATUS_OVF];
  end

  assign pinRelease = srcBit;

  always_comb begin
    busRdata = '0;
    unique case (int'(busAddr))
      ADDR_CTRL: begin
        busRdata[CTRL_EN]   = enBit;
        busRdata[CTRL_SRC]  = srcBit;
        busRdata[CTRL_EDGE] = edgeBit;
        busRdata[CTRL_PIN]  = syncLevel;
      end
      ADDR_COUNT:  busRdata = countVal;
      ADDR_STATUS: busRdata[STATUS_OVF] = ovfState;
      default:     busRdata = '0;
    endcase
  end
endmodule

// File: rtl/edge_event_timer.sv
module edge_event_timer
  import edge_timer_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              eventPin,
  input  logic              cycleStrobe,
  output logic              ovfFlag,
  output logic              pinRelease
);
  ctrlStrobes_t      strobes;
  logic [DATA_W-1:0] countVal;

  et_control #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
  ) uControl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrite(busWrite),
    .ctrlWdata(busWdata[CTRL_W-1:0]), .busRdata(busRdata),
    .eventPin(eventPin), .cycleStrobe(cycleStrobe),
    .countVal(countVal), .ovfState(ovfFlag),
    .strobes(strobes), .pinRelease(pinRelease)
  );

  et_counter #(.CNT_W(DATA_W)) uCounter (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .loadValue(busWdata),
    .countVal(countVal), .ovfFlag(ovfFlag)
  );
endmodule

// File: rtl/edge_event_timer_checker.sv
module edge_event_timer_checker
  import edge_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrite,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              cycleStrobe,
  input logic [DATA_W-1:0] countVal,
  input logic              ovfFlag,
  input logic              pinRelease
);
  logic countWr, ctrlWr, ovfClr;
  assign countWr = busWrite && (busAddr == ADDR_W'(ADDR_COUNT));
  assign ctrlWr  = busWrite && (busAddr == ADDR_W'(ADDR_CTRL));
  assign ovfClr  = busWrite && (busAddr == ADDR_W'(ADDR_STATUS)) && busWdata[STATUS_OVF];

  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    countWr |=> countVal == $past(busWdata));

  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    !countWr |=> (countVal == $past(countVal)) ||
                 (countVal == $past(countVal) + DATA_W'(1)));

  assert_internal_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!pinRelease && !cycleStrobe && !countWr && !ctrlWr) |=> $stable(countVal));

  assert_release_tracks_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> pinRelease == $past(busWdata[CTRL_SRC]));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag);

  assert_wrap_sets_R8: assert property (@(posedge clk) disable iff (!rstN)
    (countVal == '1 && !countWr) |=> (countVal != '0) || ovfFlag);

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(ADDR_CTRL)) |-> (busRdata[7:6] == 2'b00 && busRdata[4:3] == 2'b00));
endmodule

bind edge_event_timer edge_event_timer_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChecker (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
  .busWdata(busWdata), .busRdata(busRdata), .cycleStrobe(cycleStrobe),
  .countVal(countVal), .ovfFlag(ovfFlag), .pinRelease(pinRelease)
);

// File: tb/edge_event_timer_test.sv
`timescale 1ns/100ps
module edge_event_timer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWrite = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       eventPin = 1'b0;
  logic       cycleStrobe = 1'b0;
  logic       ovfFlag;
  logic       pinRelease;

  always #2.5 clk = ~clk;

  edge_event_timer uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .eventPin(eventPin),
    .cycleStrobe(cycleStrobe), .ovfFlag(ovfFlag), .pinRelease(pinRelease)
  );

  // reference state built from the requirements
  logic [2:0] mCtrl = '0;
  logic [7:0] mCount = '0;
  logic       mOvf = 1'b0;
  logic       mS1 = 1'b0, mS2 = 1'b0, mPrev = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRead(logic [1:0] a);
    case (a)
      2'd0:    return {2'b00, mS2, 2'b00, mCtrl};
      2'd1:    return mCount;
      2'd2:    return {7'd0, mOvf};
      default: return 8'h00;
    endcase
  endfunction

  // one clock: model next state from current inputs, then advance
  task automatic step();
    logic wrC, wrN, wrS, rise, fall, ev, wrap;
    logic [7:0] nCount;
    wrC  = busWrite && busAddr == 2'd0;
    wrN  = busWrite && busAddr == 2'd1;
    wrS  = busWrite && busAddr == 2'd2;
    rise = mS2 && !mPrev;
    fall = !mS2 && mPrev;
    ev   = mCtrl[2] && (mCtrl[1] ? (mCtrl[0] ? fall : rise) : cycleStrobe);
    wrap = ev && !wrN && mCount == 8'hFF;
    nCount = wrN ? busWdata : (ev ? mCount + 8'd1 : mCount);
    @(posedge clk);
    mOvf   = wrap | (mOvf & ~(wrS & busWdata[0]));
    mCount = nCount;
    if (wrC) mCtrl = busWdata[2:0];
    mPrev = mS2; mS2 = mS1; mS1 = eventPin;
    @(negedge clk);
    busWrite = 1'b0;
    cycleStrobe = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    step();
  endtask

  task automatic readAt(logic [1:0] a, output logic [7:0] v);
    busAddr = a;
    #0.2;
    v = busRdata;
  endtask

  task automatic checkAll(string req);
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      readAt(2'(a), v);
      check(req, v, expRead(2'(a)));
    end
    check({req, " ovfFlag"}, {7'd0, ovfFlag}, {7'd0, mOvf});
    check({req, " pinRelease R9"}, {7'd0, pinRelease}, {7'd0, mCtrl[1]});
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    @(negedge clk);
    steps(4);
    rstN = 1'b1;
    // R1: reset state
    checkAll("R1");
    readAt(2'd0, v); check("R1 ctrl", v, 8'h00);

    // R2: disabled holds
    wr(2'd0, 8'h00);
    for (int i = 0; i < 4; i++) begin cycleStrobe = 1'b1; eventPin = ~eventPin; step(); end
    steps(3);
    readAt(2'd1, v); check("R2 halted", v, 8'h00);

    // R3: internal source, pin ignored
    eventPin = 1'b0; steps(3);
    wr(2'd0, 8'h04);
    for (int i = 0; i < 5; i++) begin cycleStrobe = 1'b1; step(); step(); end
    readAt(2'd1, v); check("R3 count", v, 8'd5);
    for (int i = 0; i < 4; i++) begin eventPin = ~eventPin; steps(2); end
    steps(3);
    readAt(2'd1, v); check("R3 pin ignored", v, 8'd5);
    checkAll("R3");

    // R4: external rising, strobe ignored
    eventPin = 1'b0; steps(3);
    wr(2'd0, 8'h06);
    readAt(2'd0, v); check("R9 release", {7'd0, pinRelease}, 8'd1);
    eventPin = 1'b1; cycleStrobe = 1'b1; step();
    cycleStrobe = 1'b1; step();
    readAt(2'd1, v); check("R4 latency before", v, 8'd5);
    step();
    readAt(2'd1, v); check("R4 rising", v, 8'd6);
    eventPin = 1'b0; steps(4);
    readAt(2'd1, v); check("R4 falling not counted", v, 8'd6);
    wr(2'd0, 8'h07);
    eventPin = 1'b1; steps(4);
    eventPin = 1'b0; steps(4);
    readAt(2'd1, v); check("R4 falling", v, 8'd7);
    checkAll("R4");

    // R5: edge-select rewrite on steady level
    eventPin = 1'b1; steps(4);
    readAt(2'd1, v); check("R5 pre", v, 8'd7);
    wr(2'd0, 8'h06); steps(3); wr(2'd0, 8'h07); steps(3);
    eventPin = 1'b0; steps(4);
    wr(2'd0, 8'h06); steps(3); wr(2'd0, 8'h07); steps(3);
    readAt(2'd1, v); check("R5 no spurious", v, 8'd8);

    // R6: readback layout, bit 5 follows pin and ignores writes
    eventPin = 1'b0; steps(3);
    wr(2'd0, 8'hFF);
    readAt(2'd0, v); check("R6 ctrl readback", v, 8'h07);
    eventPin = 1'b1; steps(3);
    wr(2'd0, 8'h03);
    readAt(2'd0, v); check("R6 pin bit", v, 8'h23);
    checkAll("R6");

    // R7: load wins over event
    wr(2'd0, 8'h04);
    busAddr = 2'd1; busWdata = 8'h40; busWrite = 1'b1; cycleStrobe = 1'b1; step();
    readAt(2'd1, v); check("R7 load wins", v, 8'h40);

    // R8: wrap, sticky, clear, set beats clear
    wr(2'd1, 8'hFE);
    cycleStrobe = 1'b1; step();
    check("R8 no ovf yet", {7'd0, ovfFlag}, 8'd0);
    cycleStrobe = 1'b1; step();
    readAt(2'd1, v); check("R8 wrapped", v, 8'h00);
    check("R8 ovf set", {7'd0, ovfFlag}, 8'd1);
    for (int i = 0; i < 3; i++) begin cycleStrobe = 1'b1; step(); end
    wr(2'd2, 8'h00);
    check("R8 sticky", {7'd0, ovfFlag}, 8'd1);
    wr(2'd2, 8'h01);
    check("R8 cleared", {7'd0, ovfFlag}, 8'd0);
    wr(2'd1, 8'hFF);
    busAddr = 2'd2; busWdata = 8'h01; busWrite = 1'b1; cycleStrobe = 1'b1; step();
    check("R8 set beats clear", {7'd0, ovfFlag}, 8'd1);

    // R10: unmapped address
    readAt(2'd3, v); check("R10 addr3", v, 8'h00);
    checkAll("R10");

    // random mix against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 12) begin
        busAddr = 2'($urandom_range(0, 3));
        busWdata = 8'($urandom);
        if (busAddr == 2'd1 && $urandom_range(0, 1) == 1) busWdata = 8'hFE;
        busWrite = 1'b1;
      end
      cycleStrobe = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 3) == 0) eventPin = ~eventPin;
      step();
      if (n % 8 == 7) checkAll("R4 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule